// File: doc/BRIEF.md
# Code Fetch Address Router

This block owns the program counter of a 24-bit code address space, split into an 8-bit segment and a 16-bit offset. It loads a new counter value on demand, advances it by one on a step strobe, and applies per-segment rollover rules when the offset runs past its last byte. Most segments roll over within themselves. The top boot segment and the segment below it both continue at the boot address. The lowest two segments form a closed pair.

From the current counter, the block forms the effective memory address and a select that steers the fetch either to on-chip code memory or to the external bus. The on-chip store covers the lower 32 KB of the boot segment. An external-access strap is captured while reset is held and kept until the next reset. When the strap is low, everything goes to the bus.

A live alias-disable input controls an optional window. While the input is low, the top 16 KB of segment 00 are folded onto the upper half of the on-chip range. When the on-chip store is off, the folded address is sent to the bus instead. A parameter builds a variant with no on-chip store, in which the select never asserts.

Top module: `code_fetch_router`

## Requirements
- R1: While `rstN` is low the counter is set to FF:0000h (`pcOut` = 24'hFF0000). It holds that value in the first cycle after reset is released.
- R2: `strapPin` is sampled on every clock edge at which `rstN` is low. After reset is released, changes on `strapPin` have no effect on `onChipSel` until the next reset.
- R3: When `loadPc` is high, `pcOut` takes the value of `pcIn` on the next clock edge. `loadPc` wins over `stepPc` when both are high.
- R4: On a step (`stepPc` high and `loadPc` low), if the offset `pcOut[15:0]` is not FFFFh, `pcOut` becomes `pcOut`+1 on the next edge.
- R5: Stepping from FF:FFFFh yields FF:0000h.
- R6: Stepping from FE:FFFFh yields FF:0000h.
- R7: Stepping from 01:FFFFh yields 00:0000h.
- R8: Stepping from 00:FFFFh yields 01:0000h. For any other segment s, stepping from s:FFFFh yields s:0000h.
- R9: With the captured strap at 1, `onChipSel` is high exactly when `memAddr` lies in FF:0000h–FF:7FFFh.
- R10: With the captured strap at 0, `onChipSel` is always low.
- R11: While `aliasOff` is low and `pcOut` lies in 00:C000h–00:FFFFh, `memAddr` is FF:4000h plus `pcOut[13:0]`. The select follows R9/R10 on that translated address.
- R12: Outside that window, or with `aliasOff` high, `memAddr` equals `pcOut`.
- R13: Built with `ONCHIP_PRESENT` = 0, `onChipSel` is low for every address and strap value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low. The strap is captured while it is low. |
| strapPin | input | 1 | External-access strap: 1 enables on-chip code, 0 forces the bus |
| aliasOff | input | 1 | 1 removes the segment-00 alias window |
| loadPc | input | 1 | Load `pcIn` into the counter |
| pcIn | input | 24 | New counter value {segment, offset} |
| stepPc | input | 1 | Advance the counter by one with segment rollover |
| pcOut | output | 24 | Current counter |
| memAddr | output | 24 | Effective fetch address after alias folding |
| onChipSel | output | 1 | 1 = fetch from on-chip code, 0 = external bus |

## Verification
A corrupted counter appears on `pcOut` one edge after the load or step that caused it, and it propagates in the same cycle to `memAddr` and `onChipSel`. A wrong rollover rule therefore shows up immediately, but only when the step hits offset FFFFh, so every segment is stepped from its last byte. A captured strap that drifts after reset is not visible in `pcOut`. It surfaces only as a change in the select at a boot-range address, so the pin is toggled after reset and the routing is swept again.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic load;
    logic step;
  } pcStrobe_t;

endpackage

// File: rtl/cfr_ctrl.sv
module cfr_ctrl
  import cfr_pkg::*;
#(
  parameter bit ONCHIP_PRESENT = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      strapPin,
  input  logic      loadReq,
  input  logic      stepReq,
  output pcStrobe_t strobe,
  output logic      strapHeld,
  output logic      onChipEn
);

  logic strapQ;

  // The strap follows the pin only while reset is asserted
  always_ff @(posedge clk) begin
    if (!rstN) strapQ <= strapPin;
  end

  // A load takes priority; no strobe fires during reset
  always_comb begin
    strobe.load = rstN & loadReq;
    strobe.step = rstN & stepReq & ~loadReq;
  end

  assign strapHeld = strapQ;

  generate
    if (ONCHIP_PRESENT) begin : g_withStore
      assign onChipEn = strapQ;
    end else begin : g_romless
      assign onChipEn = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cfr_pc_path.sv
module cfr_pc_path
  import cfr_pkg::*;
#(
  parameter int                SEG_W    = 8,
  parameter int                OFF_W    = 16,
  parameter logic [SEG_W-1:0]  BOOT_SEG = 8'hFF
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pcStrobe_t                strobe,
  input  logic [SEG_W+OFF_W-1:0]   pcIn,
  output logic [SEG_W+OFF_W-1:0]   pcOut
);

  localparam int               ADDR_W       = SEG_W + OFF_W;
  localparam logic [SEG_W-1:0] SEG_PRE_BOOT = BOOT_SEG - SEG_W'(1);
  localparam logic [SEG_W-1:0] SEG_LOW0     = '0;
  localparam logic [SEG_W-1:0] SEG_LOW1     = SEG_W'(1);
  localparam logic [ADDR_W-1:0] RESET_PC    = {BOOT_SEG, {OFF_W{1'b0}}};

  logic [ADDR_W-1:0] pcQ;
  logic [SEG_W-1:0]  curSeg;
  logic [OFF_W-1:0]  curOff;
  logic [SEG_W-1:0]  nextSeg;
  logic [OFF_W-1:0]  nextOff;

  assign curSeg = pcQ[ADDR_W-1:OFF_W];
  assign curOff = pcQ[OFF_W-1:0];

  // Successor address with per-segment rollover
  always_comb begin
    nextSeg = curSeg;
    nextOff = curOff + OFF_W'(1);
    if (curOff == {OFF_W{1'b1}}) begin
      nextOff = '0;
      if (curSeg == BOOT_SEG)          nextSeg = BOOT_SEG;
      else if (curSeg == SEG_PRE_BOOT) nextSeg = BOOT_SEG;
      else if (curSeg == SEG_LOW1)     nextSeg = SEG_LOW0;
      else if (curSeg == SEG_LOW0)     nextSeg = SEG_LOW1;
      else                             nextSeg = curSeg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            pcQ <= RESET_PC;
    else if (strobe.load) pcQ <= pcIn;
    else if (strobe.step) pcQ <= {nextSeg, nextOff};
  end

  assign pcOut = pcQ;

endmodule

// File: rtl/cfr_route.sv
module cfr_route #(
  parameter int               SEG_W     = 8,
  parameter int               OFF_W     = 16,
  parameter int               ONCHIP_AW = 15,
  parameter int               ALIAS_AW  = 14,
  parameter logic [SEG_W-1:0] BOOT_SEG  = 8'hFF,
  parameter logic [SEG_W-1:0] ALIAS_SEG = 8'h00
) (
  input  logic [SEG_W+OFF_W-1:0] pc,
  input  logic                   aliasOff,
  input  logic                   onChipEn,
  output logic [SEG_W+OFF_W-1:0] memAddr,
  output logic                   onChipSel
);

  localparam int               ADDR_W     = SEG_W + OFF_W;
  // First offset of the alias window (top 2^ALIAS_AW bytes of the segment)
  localparam logic [OFF_W-1:0] ALIAS_LOW  = OFF_W'((1 << OFF_W) - (1 << ALIAS_AW));
  localparam logic [OFF_W-1:0] ALIAS_MASK = OFF_W'((1 << ALIAS_AW) - 1);
  // Target of the window: upper part of the on-chip range
  localparam logic [OFF_W-1:0] ALIAS_BASE = OFF_W'((1 << ONCHIP_AW) - (1 << ALIAS_AW));
  localparam logic [OFF_W-1:0] ONCHIP_TOP = OFF_W'(1 << ONCHIP_AW);

  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  logic             aliasHit;
  logic [SEG_W-1:0] memSeg;
  logic [OFF_W-1:0] memOff;
  logic             inRange;

  assign seg = pc[ADDR_W-1:OFF_W];
  assign off = pc[OFF_W-1:0];

  assign aliasHit = !aliasOff && (seg == ALIAS_SEG) && (off >= ALIAS_LOW);

  always_comb begin
    if (aliasHit) begin
      memSeg = BOOT_SEG;
      memOff = ALIAS_BASE | (off & ALIAS_MASK);
    end else begin
      memSeg = seg;
      memOff = off;
    end
  end

  // One range compare serves both direct and folded fetches
  assign inRange   = (memSeg == BOOT_SEG) && (memOff < ONCHIP_TOP);
  assign memAddr   = {memSeg, memOff};
  assign onChipSel = onChipEn && inRange;

endmodule

// File: rtl/code_fetch_router.sv
module code_fetch_router
  import cfr_pkg::*;
#(
  parameter int               SEG_W          = 8,
  parameter int               OFF_W          = 16,
  parameter int               ONCHIP_AW      = 15,
  parameter int               ALIAS_AW       = 14,
  parameter bit               ONCHIP_PRESENT = 1'b1,
  parameter logic [SEG_W-1:0] BOOT_SEG       = 8'hFF,
  parameter logic [SEG_W-1:0] ALIAS_SEG      = 8'h00
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   strapPin,
  input  logic                   aliasOff,
  input  logic                   loadPc,
  input  logic [SEG_W+OFF_W-1:0] pcIn,
  input  logic                   stepPc,
  output logic [SEG_W+OFF_W-1:0] pcOut,
  output logic [SEG_W+OFF_W-1:0] memAddr,
  output logic                   onChipSel
);

  pcStrobe_t strobe;
  logic      strapQ;
  logic      onChipEn;

  cfr_ctrl #(
    .ONCHIP_PRESENT(ONCHIP_PRESENT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .strapPin (strapPin),
    .loadReq  (loadPc),
    .stepReq  (stepPc),
    .strobe   (strobe),
    .strapHeld(strapQ),
    .onChipEn (onChipEn)
  );

  cfr_pc_path #(
    .SEG_W   (SEG_W),
    .OFF_W   (OFF_W),
    .BOOT_SEG(BOOT_SEG)
  ) u_pc (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .pcIn  (pcIn),
    .pcOut (pcOut)
  );

  cfr_route #(
    .SEG_W    (SEG_W),
    .OFF_W    (OFF_W),
    .ONCHIP_AW(ONCHIP_AW),
    .ALIAS_AW (ALIAS_AW),
    .BOOT_SEG (BOOT_SEG),
    .ALIAS_SEG(ALIAS_SEG)
  ) u_route (
    .pc       (pcOut),
    .aliasOff (aliasOff),
    .onChipEn (onChipEn),
    .memAddr  (memAddr),
    .onChipSel(onChipSel)
  );

endmodule

// File: rtl/cfr_checker.sv
module cfr_checker #(
  parameter int               SEG_W    = 8,
  parameter int               OFF_W    = 16,
  parameter logic [SEG_W-1:0] BOOT_SEG = 8'hFF
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   loadPc,
  input logic                   stepPc,
  input logic                   aliasOff,
  input logic [SEG_W+OFF_W-1:0] pcIn,
  input logic [SEG_W+OFF_W-1:0] pcOut,
  input logic [SEG_W+OFF_W-1:0] memAddr,
  input logic                   onChipSel,
  input logic                   strapHeld
);

  localparam int ADDR_W = SEG_W + OFF_W;

  p_reset_pc_r1: assert property (@(posedge clk)
    $rose(rstN) |-> pcOut == {BOOT_SEG, {OFF_W{1'b0}}});

  p_strap_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(strapHeld));

  p_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadPc |=> pcOut == $past(pcIn));

  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stepPc && !loadPc && pcOut[OFF_W-1:0] != {OFF_W{1'b1}})
      |=> pcOut == ADDR_W'($past(pcOut) + 1));

  p_wrap_boot_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stepPc && !loadPc && pcOut == {BOOT_SEG, {OFF_W{1'b1}}})
      |=> pcOut == {BOOT_SEG, {OFF_W{1'b0}}});

  p_wrap_preboot_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stepPc && !loadPc && pcOut == {SEG_W'(BOOT_SEG - 1'b1), {OFF_W{1'b1}}})
      |=> pcOut == {BOOT_SEG, {OFF_W{1'b0}}});

  p_wrap_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stepPc && !loadPc && pcOut == {SEG_W'(1), {OFF_W{1'b1}}})
      |=> pcOut == '0);

  p_onchip_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    onChipSel |-> (memAddr[ADDR_W-1:OFF_W] == BOOT_SEG) && !memAddr[OFF_W-1] && strapHeld);

  p_no_strap_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strapHeld |-> !onChipSel);

  p_alias_fold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!aliasOff && pcOut[ADDR_W-1:OFF_W] == '0 && pcOut[OFF_W-1:OFF_W-2] == 2'b11)
      |-> memAddr == {BOOT_SEG, 2'b01, pcOut[OFF_W-3:0]});

  p_passthru_r12: assert property (@(posedge clk) disable iff (!rstN)
    aliasOff |-> memAddr == pcOut);

endmodule

bind code_fetch_router cfr_checker #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .BOOT_SEG(BOOT_SEG)
) u_cfrChecker (
  .clk      (clk),
  .rstN     (rstN),
  .loadPc   (loadPc),
  .stepPc   (stepPc),
  .aliasOff (aliasOff),
  .pcIn     (pcIn),
  .pcOut    (pcOut),
  .memAddr  (memAddr),
  .onChipSel(onChipSel),
  .strapHeld(strapQ)
);

// File: tb/test_code_fetch_router.sv
module test_code_fetch_router;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strapPin = 1'b1;
  logic        aliasOff = 1'b0;
  logic        loadPc = 1'b0;
  logic        stepPc = 1'b0;
  logic [23:0] pcIn = '0;
  logic [23:0] pcOut, memAddr;
  logic        onChipSel;
  logic [23:0] pcOutR, memAddrR;
  logic        onChipSelR;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  code_fetch_router i_code_fetch_router (
    .clk(clk), .rstN(rstN), .strapPin(strapPin), .aliasOff(aliasOff),
    .loadPc(loadPc), .pcIn(pcIn), .stepPc(stepPc),
    .pcOut(pcOut), .memAddr(memAddr), .onChipSel(onChipSel)
  );

  code_fetch_router #(.ONCHIP_PRESENT(1'b0)) i_code_fetch_router_romless (
    .clk(clk), .rstN(rstN), .strapPin(strapPin), .aliasOff(aliasOff),
    .loadPc(loadPc), .pcIn(pcIn), .stepPc(stepPc),
    .pcOut(pcOutR), .memAddr(memAddrR), .onChipSel(onChipSelR)
  );

  // ---------- expected-value model from the requirements ----------
  function automatic logic [23:0] expNext(input logic [23:0] p);
    if (p[15:0] != 16'hFFFF) return p + 24'd1;
    case (p[23:16])
      8'hFF:   return 24'hFF0000;
      8'hFE:   return 24'hFF0000;
      8'h01:   return 24'h000000;
      8'h00:   return 24'h010000;
      default: return {p[23:16], 16'h0000};
    endcase
  endfunction

  function automatic logic [23:0] expMem(input logic [23:0] p, input logic aOff);
    if (!aOff && p[23:16] == 8'h00 && p[15:14] == 2'b11)
      return 24'hFF4000 + {10'd0, p[13:0]};
    return p;
  endfunction

  function automatic logic expOn(input logic [23:0] m, input logic strap);
    return strap && m[23:16] == 8'hFF && m[15] == 1'b0;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk);
    rstN = 1'b0; strapPin = strap; loadPc = 1'b0; stepPc = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doLoad(input logic [23:0] a);
    loadPc = 1'b1; pcIn = a;
    @(negedge clk);
    loadPc = 1'b0;
  endtask

  task automatic doStep();
    stepPc = 1'b1;
    @(negedge clk);
    stepPc = 1'b0;
  endtask

  // Routing checks at the current counter for both builds
  task automatic checkRoute(input logic strap);
    logic [23:0] m;
    m = expMem(pcOut, aliasOff);
    if (!aliasOff && pcOut[23:16] == 8'h00 && pcOut[15:14] == 2'b11)
      check("R11", "memAddr in alias window", memAddr, m);
    else
      check("R12", "memAddr passthrough", memAddr, m);
    if (strap)
      check("R9", "onChipSel with strap 1", {23'd0, onChipSel}, {23'd0, expOn(m, 1'b1)});
    else
      check("R10", "onChipSel with strap 0", {23'd0, onChipSel}, 24'd0);
    check("R13", "romless onChipSel", {23'd0, onChipSelR}, 24'd0);
    check("R13", "romless memAddr", memAddrR, m);
  endtask

  task automatic sweepRoute(input logic strap);
    logic [7:0] segs [5];
    segs = '{8'h00, 8'h01, 8'h7F, 8'hFE, 8'hFF};
    for (int a = 0; a < 2; a++) begin
      aliasOff = a[0];
      for (int s = 0; s < 5; s++) begin
        for (int o = 0; o < 65536; o += 1024) begin
          doLoad({segs[s], o[15:0]});
          checkRoute(strap);
          doLoad({segs[s], o[15:0] | 16'h03FF});
          checkRoute(strap);
        end
      end
    end
    aliasOff = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    // R1: reset value and first cycle after release
    doReset(1'b1);
    check("R1", "pc right after reset", pcOut, 24'hFF0000);
    @(negedge clk);
    check("R1", "pc held after reset", pcOut, 24'hFF0000);
    check("R9", "boot address on-chip", {23'd0, onChipSel}, 24'd1);

    // R2: pin changes after reset are ignored
    strapPin = 1'b0;
    doLoad(24'hFF1234);
    check("R2", "strap pin dropped after reset", {23'd0, onChipSel}, 24'd1);

    // Routing sweep with strap captured at 1 (pin now 0 throughout: R2)
    sweepRoute(1'b1);

    // R3: load wins over step
    doLoad(24'hFF0010);
    loadPc = 1'b1; stepPc = 1'b1; pcIn = 24'h123456;
    @(negedge clk);
    loadPc = 1'b0; stepPc = 1'b0;
    check("R3", "load priority over step", pcOut, 24'h123456);

    // R4..R8: step from two offsets in every segment
    for (int s = 0; s < 256; s++) begin
      logic [23:0] p;
      p = {s[7:0], s[7:0], s[7:0]};
      doLoad(p);
      doStep();
      check("R4", "step inside segment", pcOut, expNext(p));
      p = {s[7:0], 16'hFFFF};
      doLoad(p);
      doStep();
      case (s)
        255:     check("R5", "wrap boot segment", pcOut, expNext(p));
        254:     check("R6", "wrap pre-boot segment", pcOut, expNext(p));
        1:       check("R7", "wrap segment 01", pcOut, expNext(p));
        default: check("R8", "wrap other segment", pcOut, expNext(p));
      endcase
    end

    // Held step across the boot rollover
    doLoad(24'hFFFFFE);
    stepPc = 1'b1;
    @(negedge clk); check("R4", "held step 1", pcOut, 24'hFFFFFF);
    @(negedge clk); check("R5", "held step 2", pcOut, 24'hFF0000);
    @(negedge clk); check("R4", "held step 3", pcOut, 24'hFF0001);
    stepPc = 1'b0;

    // Strap captured at 0; pin raised after reset must not matter
    doReset(1'b0);
    check("R1", "pc after second reset", pcOut, 24'hFF0000);
    check("R10", "boot address external", {23'd0, onChipSel}, 24'd0);
    strapPin = 1'b1;
    doLoad(24'hFF0000);
    check("R2", "strap pin raised after reset", {23'd0, onChipSel}, 24'd0);
    sweepRoute(1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule